// File: doc/BRIEF.md
# Tagged Set-Associative Translation Cache

This block caches virtual-to-physical translations for 4 KiB pages. A requester presents a virtual address, a read/write flag and a context identifier. One cycle after the request is accepted, the block answers with the physical address. On a hit, that address is built from the cached frame number and the untouched page offset. On a miss, the block raises a page-walk request over a valid/ready handshake. It then waits for the walk response and installs the translation in the selected set. It answers with the returned frame and emits a page-table-entry update. That update sets the accessed bit and, for writes, the dirty bit, but only when the walk reported them clear.

Entries carry a context tag. Entries that belong to other contexts never match a lookup. They stay resident and compete for replacement with the current context's entries. A parameter picks how the set index is formed: either the low page-number bits, or two adjacent page-number fields XORed together. Two flush inputs are provided. One drops every entry. The other drops only the entries of one context.

Top module: `xlat_cache`

## Requirements
- R1: The response appears in the cycle after a request is accepted or after a walk response arrives. The response address is the frame number concatenated with address bits [11:0].
- R2: The set index has width I = log2(SETS). With XOR_MAP=1 it is va[12+:I] XOR va[12+I+:I]. With XOR_MAP=0 it is va[12+:I]. Pages whose indices are equal share one set of WAYS entries.
- R3: A lookup matches only a valid entry whose context tag and full page number both equal the request's. Entries of other contexts stay resident and occupy ways of their set.
- R4: On a miss, walk_req_valid_o rises in the next cycle. It holds walk_vpn_o stable until walk_req_ready_i is seen. req_ready_o stays low from acceptance until the response cycle, and rsp_valid_o stays low while req_ready_o is low.
- R5: A miss installs the returned frame and answers with rsp_hit_o=0. In the same cycle it emits an update whose accessed flag is 1 exactly when the walk reported the accessed bit clear.
- R6: A hit raises no walk request and never emits an accessed-bit update. An accessed bit cleared while the entry is cached therefore stays clear until a later miss on that page.
- R7: A write sets the dirty flag in the update when the dirty state is clear. On a miss that state is the walk-reported dirty bit; on a hit it is the cached entry's dirty bit. Otherwise the dirty flag is 0. pte_upd_valid_o is high exactly when either flag is set.
- R8: A fill takes the lowest-numbered invalid way of its set. If every way is valid, it takes the least recently used way, where hits and fills both count as use.
- R9: A pulse on flush_all_i invalidates every entry.
- R10: A pulse on flush_ctx_i invalidates only the entries whose context equals flush_ctx_id_i.
- R11: After reset, every entry is invalid, req_ready_o is 1, and rsp_valid_o, walk_req_valid_o and pte_upd_valid_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_va_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | Access is a write |
| req_ctx_i | input | CTX_W | Requesting context |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Response came from a cached entry |
| rsp_pa_o | output | PFN_W+12 | Physical address |
| walk_req_valid_o | output | 1 | Page-walk request |
| walk_req_ready_i | input | 1 | Walker accepts the request |
| walk_vpn_o | output | VA_W-12 | Page number to walk |
| walk_rsp_valid_i | input | 1 | Walk result strobe |
| walk_rsp_pfn_i | input | PFN_W | Frame number from the walk |
| walk_rsp_acc_i | input | 1 | Accessed bit currently in the entry |
| walk_rsp_dirty_i | input | 1 | Dirty bit currently in the entry |
| pte_upd_valid_o | output | 1 | Page-table-entry update strobe |
| pte_upd_vpn_o | output | VA_W-12 | Page number of the update |
| pte_upd_set_acc_o | output | 1 | Update sets the accessed bit |
| pte_upd_set_dirty_o | output | 1 | Update sets the dirty bit |
| flush_all_i | input | 1 | Invalidate all entries |
| flush_ctx_i | input | 1 | Invalidate one context |
| flush_ctx_id_i | input | CTX_W | Context to invalidate |

## Verification
A corrupted valid bit, context tag or replacement age does not show up immediately. It shows up on the next lookup of the affected set, as a response whose hit flag or frame differs from the model. It can also show up as a walk request that should not occur, or one that is missing. Such a lookup can come many requests after the fault. The bench therefore replays access streams that revisit every set, so that each fault is exposed within a few lookups. A wrong update flag appears in the very response cycle, because the update and the response leave the block together.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WREQ, ST_WAIT} xlat_state_e;
endpackage

// File: rtl/xlat_index.sv
module xlat_index #(
  parameter int IDX_W   = 8,
  parameter bit XOR_MAP = 1'b1,
  localparam int FOLD_W = XOR_MAP ? 2 * IDX_W : IDX_W
) (
  input  logic [FOLD_W-1:0] vpn_lo_i,
  output logic [IDX_W-1:0]  idx_o
);
  if (XOR_MAP) begin : g_xor
    assign idx_o = vpn_lo_i[IDX_W-1:0] ^ vpn_lo_i[FOLD_W-1:IDX_W];
  end else begin : g_lin
    assign idx_o = vpn_lo_i;
  end
endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
  parameter int SETS = 256,
  parameter int WAYS = 6,
  localparam int IDX_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_set_i,
  input  logic [WAY_W-1:0] touch_way_i,
  input  logic [IDX_W-1:0] rd_set_i,
  output logic [WAY_W-1:0] oldest_o
);
  // age 0 = most recent; ages of a set always form a permutation
  logic [WAY_W-1:0] age_q [SETS][WAYS];
  logic [WAYS-1:0]  old_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way_i)
          age_q[touch_set_i][w] <= '0;
        else if (age_q[touch_set_i][w] < age_q[touch_set_i][touch_way_i])
          age_q[touch_set_i][w] <= age_q[touch_set_i][w] + 1'b1;
      end
    end
  end

  always_comb begin
    oldest_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      old_vec[w] = (age_q[rd_set_i][w] == WAY_W'(WAYS - 1));
      if (old_vec[w]) oldest_o = WAY_W'(w);
    end
  end

  AST_ONE_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(old_vec) == 1); // R8
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PFN_W   = 20,
  parameter int CTX_W   = 4,
  parameter int SETS    = 256,
  parameter int WAYS    = 6,
  parameter bit XOR_MAP = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  input  logic               req_write_i,
  input  logic [CTX_W-1:0]   req_ctx_i,
  output logic               rsp_valid_o,
  output logic               rsp_hit_o,
  output logic [PFN_W+11:0]  rsp_pa_o,
  output logic               walk_req_valid_o,
  input  logic               walk_req_ready_i,
  output logic [VA_W-13:0]   walk_vpn_o,
  input  logic               walk_rsp_valid_i,
  input  logic [PFN_W-1:0]   walk_rsp_pfn_i,
  input  logic               walk_rsp_acc_i,
  input  logic               walk_rsp_dirty_i,
  output logic               pte_upd_valid_o,
  output logic [VA_W-13:0]   pte_upd_vpn_o,
  output logic               pte_upd_set_acc_o,
  output logic               pte_upd_set_dirty_o,
  input  logic               flush_all_i,
  input  logic               flush_ctx_i,
  input  logic [CTX_W-1:0]   flush_ctx_id_i
);
  localparam int VPN_W  = VA_W - 12;
  localparam int IDX_W  = $clog2(SETS);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int FOLD_W = XOR_MAP ? 2 * IDX_W : IDX_W;

  xlat_state_e state_q;

  logic             ent_vld_q [SETS][WAYS];
  logic [CTX_W-1:0] ent_ctx_q [SETS][WAYS];
  logic [VPN_W-1:0] ent_vpn_q [SETS][WAYS];
  logic [PFN_W-1:0] ent_pfn_q [SETS][WAYS];
  logic             ent_dty_q [SETS][WAYS];

  logic [VPN_W-1:0] req_vpn;
  logic [IDX_W-1:0] lk_idx, idx_q;
  logic [VPN_W-1:0] vpn_q;
  logic [11:0]      off_q;
  logic             wr_q;
  logic [CTX_W-1:0] ctx_q;
  logic [WAYS-1:0]  hit_vec;
  logic             lk_hit, accept, fill, wr_clean_hit;
  logic [WAY_W-1:0] hit_way, victim, oldest;
  logic             touch;
  logic [IDX_W-1:0] touch_set;
  logic [WAY_W-1:0] touch_way;

  assign req_vpn          = req_va_i[VA_W-1:12];
  assign req_ready_o      = (state_q == ST_IDLE);
  assign walk_req_valid_o = (state_q == ST_WREQ);
  assign walk_vpn_o       = vpn_q;
  assign accept           = req_valid_i && req_ready_o;
  assign fill             = (state_q == ST_WAIT) && walk_rsp_valid_i;

  xlat_index #(.IDX_W(IDX_W), .XOR_MAP(XOR_MAP)) u_index (
    .vpn_lo_i (req_vpn[FOLD_W-1:0]),
    .idx_o    (lk_idx)
  );

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec[w] = ent_vld_q[lk_idx][w] && (ent_ctx_q[lk_idx][w] == req_ctx_i) &&
                   (ent_vpn_q[lk_idx][w] == req_vpn);
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
    lk_hit = |hit_vec;
    wr_clean_hit = req_write_i && !ent_dty_q[lk_idx][hit_way];
  end

  // lowest invalid way first, else least recently used
  always_comb begin
    victim = oldest;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!ent_vld_q[idx_q][w]) victim = WAY_W'(w);
  end

  assign touch     = (accept && lk_hit) || fill;
  assign touch_set = fill ? idx_q : lk_idx;
  assign touch_way = fill ? victim : hit_way;

  xlat_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_set_i (touch_set),
    .touch_way_i (touch_way),
    .rd_set_i    (idx_q),
    .oldest_o    (oldest)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q             <= ST_IDLE;
      rsp_valid_o         <= 1'b0;
      rsp_hit_o           <= 1'b0;
      rsp_pa_o            <= '0;
      pte_upd_valid_o     <= 1'b0;
      pte_upd_vpn_o       <= '0;
      pte_upd_set_acc_o   <= 1'b0;
      pte_upd_set_dirty_o <= 1'b0;
      vpn_q               <= '0;
      off_q               <= '0;
      wr_q                <= 1'b0;
      ctx_q               <= '0;
      idx_q               <= '0;
    end else begin
      rsp_valid_o         <= 1'b0;
      pte_upd_valid_o     <= 1'b0;
      pte_upd_set_acc_o   <= 1'b0;
      pte_upd_set_dirty_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          vpn_q <= req_vpn;
          off_q <= req_va_i[11:0];
          wr_q  <= req_write_i;
          ctx_q <= req_ctx_i;
          idx_q <= lk_idx;
          if (lk_hit) begin
            rsp_valid_o         <= 1'b1;
            rsp_hit_o           <= 1'b1;
            rsp_pa_o            <= {ent_pfn_q[lk_idx][hit_way], req_va_i[11:0]};
            pte_upd_valid_o     <= wr_clean_hit;
            pte_upd_set_dirty_o <= wr_clean_hit;
            pte_upd_vpn_o       <= req_vpn;
          end else begin
            state_q <= ST_WREQ;
          end
        end
        ST_WREQ: if (walk_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (walk_rsp_valid_i) begin
          state_q             <= ST_IDLE;
          rsp_valid_o         <= 1'b1;
          rsp_hit_o           <= 1'b0;
          rsp_pa_o            <= {walk_rsp_pfn_i, off_q};
          pte_upd_valid_o     <= !walk_rsp_acc_i || (wr_q && !walk_rsp_dirty_i);
          pte_upd_set_acc_o   <= !walk_rsp_acc_i;
          pte_upd_set_dirty_o <= wr_q && !walk_rsp_dirty_i;
          pte_upd_vpn_o       <= vpn_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          ent_vld_q[s][w] <= 1'b0;
    end else begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (flush_all_i || (flush_ctx_i && ent_ctx_q[s][w] == flush_ctx_id_i))
            ent_vld_q[s][w] <= 1'b0;
      if (fill) ent_vld_q[idx_q][victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill) begin
      ent_ctx_q[idx_q][victim] <= ctx_q;
      ent_vpn_q[idx_q][victim] <= vpn_q;
      ent_pfn_q[idx_q][victim] <= walk_rsp_pfn_i;
      ent_dty_q[idx_q][victim] <= walk_rsp_dirty_i || wr_q;
    end
    if (accept && lk_hit && req_write_i) ent_dty_q[lk_idx][hit_way] <= 1'b1;
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_RSP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rsp_valid_o) |-> $past(accept) || $past(fill)); // R1
  AST_WALK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    walk_req_valid_o && !walk_req_ready_i |=> walk_req_valid_o && $stable(walk_vpn_o)); // R4
  AST_STALL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !rsp_valid_o); // R4
  AST_HIT_NO_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_hit_o |-> !pte_upd_set_acc_o); // R6
  AST_UPD_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pte_upd_valid_o |-> rsp_valid_o); // R7
endmodule

// File: tb/xlat_cache_bench.sv
module xlat_cache_bench;
  localparam int SETS = 4, WAYS = 2, CTX_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_ready, req_write = 0;
  logic [31:0] req_va = '0;
  logic [1:0]  req_ctx = '0;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_pa;
  logic        walk_req_valid, walk_req_ready = 0;
  logic [19:0] walk_vpn;
  logic        walk_rsp_valid = 0, walk_rsp_acc = 0, walk_rsp_dirty = 0;
  logic [19:0] walk_rsp_pfn = '0;
  logic        upd_valid, upd_acc, upd_dirty;
  logic [19:0] upd_vpn;
  logic        flush_all = 0, flush_ctx = 0;
  logic [1:0]  flush_id = '0;

  xlat_cache #(.VA_W(32), .PFN_W(20), .CTX_W(CTX_W), .SETS(SETS), .WAYS(WAYS), .XOR_MAP(1'b1)) u_xlat_cache (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_va_i(req_va),
    .req_write_i(req_write), .req_ctx_i(req_ctx),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_pa_o(rsp_pa),
    .walk_req_valid_o(walk_req_valid), .walk_req_ready_i(walk_req_ready), .walk_vpn_o(walk_vpn),
    .walk_rsp_valid_i(walk_rsp_valid), .walk_rsp_pfn_i(walk_rsp_pfn),
    .walk_rsp_acc_i(walk_rsp_acc), .walk_rsp_dirty_i(walk_rsp_dirty),
    .pte_upd_valid_o(upd_valid), .pte_upd_vpn_o(upd_vpn),
    .pte_upd_set_acc_o(upd_acc), .pte_upd_set_dirty_o(upd_dirty),
    .flush_all_i(flush_all), .flush_ctx_i(flush_ctx), .flush_ctx_id_i(flush_id)
  );

  int n_chk = 0, n_err = 0, tick = 0;
  bit m_vld [SETS][WAYS];
  bit [1:0]  m_ctx [SETS][WAYS];
  bit [19:0] m_vpn [SETS][WAYS];
  bit [19:0] m_pfn [SETS][WAYS];
  bit m_dty [SETS][WAYS];
  int m_stamp [SETS][WAYS];
  bit pt_acc [4][256];
  bit pt_dty [4][256];

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit [19:0] pfn_of(bit [1:0] ctx, bit [19:0] vpn);
    return 20'(vpn * 13 + ctx * 4099 + 5);
  endfunction

  // R2: XOR fold of page-number bits [1:0] and [3:2]
  function automatic int set_of(bit [19:0] vpn);
    return int'(vpn[1:0] ^ vpn[3:2]);
  endfunction

  task automatic access(bit [1:0] ctx, bit [19:0] vpn, bit [11:0] off, bit wr, string rq);
    int s, hw, vic;
    bit [19:0] pfn;
    s = set_of(vpn);
    hw = -1;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_ctx[s][w] == ctx && m_vpn[s][w] == vpn) hw = w;
    @(negedge clk);
    check({rq, " R4 ready"}, req_ready, 1);
    req_valid = 1; req_va = {vpn[19:0], off}; req_write = wr; req_ctx = ctx;
    @(negedge clk);
    req_valid = 0;
    tick++;
    if (hw >= 0) begin
      check({rq, " R1 rsp"}, rsp_valid, 1);
      check({rq, " R3 hit"}, rsp_hit, 1);
      check({rq, " R1 pa"}, rsp_pa, {m_pfn[s][hw], off});
      check({rq, " R6 nowalk"}, walk_req_valid, 0);
      check({rq, " R6 noacc"}, upd_acc, 0);
      check({rq, " R7 dirty"}, upd_dirty, wr && !m_dty[s][hw]);
      check({rq, " R7 upd"}, upd_valid, wr && !m_dty[s][hw]);
      if (wr) begin m_dty[s][hw] = 1; pt_dty[ctx][vpn[7:0]] = 1; end
      m_stamp[s][hw] = tick;
    end else begin
      check({rq, " R4 miss"}, rsp_valid, 0);
      check({rq, " R4 walk"}, walk_req_valid, 1);
      check({rq, " R4 vpn"}, walk_vpn, vpn);
      @(negedge clk);
      check({rq, " R4 hold"}, walk_req_valid, 1);
      check({rq, " R4 stall"}, req_ready, 0);
      walk_req_ready = 1;
      @(negedge clk);
      walk_req_ready = 0;
      check({rq, " R4 wdrop"}, walk_req_valid, 0);
      check({rq, " R4 stall2"}, req_ready, 0);
      pfn = pfn_of(ctx, vpn);
      walk_rsp_valid = 1; walk_rsp_pfn = pfn;
      walk_rsp_acc = pt_acc[ctx][vpn[7:0]]; walk_rsp_dirty = pt_dty[ctx][vpn[7:0]];
      @(negedge clk);
      walk_rsp_valid = 0;
      check({rq, " R5 rsp"}, rsp_valid, 1);
      check({rq, " R5 hit"}, rsp_hit, 0);
      check({rq, " R1 pa"}, rsp_pa, {pfn, off});
      check({rq, " R5 acc"}, upd_acc, !pt_acc[ctx][vpn[7:0]]);
      check({rq, " R7 dirty"}, upd_dirty, wr && !pt_dty[ctx][vpn[7:0]]);
      check({rq, " R7 upd"}, upd_valid, !pt_acc[ctx][vpn[7:0]] || (wr && !pt_dty[ctx][vpn[7:0]]));
      if (upd_valid) check({rq, " R5 uvpn"}, upd_vpn, vpn);
      // R8 model: lowest invalid, else oldest stamp
      vic = 0;
      for (int w = 1; w < WAYS; w++) if (m_stamp[s][w] < m_stamp[s][vic]) vic = w;
      for (int w = WAYS - 1; w >= 0; w--) if (!m_vld[s][w]) vic = w;
      m_vld[s][vic] = 1; m_ctx[s][vic] = ctx; m_vpn[s][vic] = vpn; m_pfn[s][vic] = pfn;
      m_dty[s][vic] = pt_dty[ctx][vpn[7:0]] || wr; m_stamp[s][vic] = tick;
      pt_acc[ctx][vpn[7:0]] = 1;
      if (wr) pt_dty[ctx][vpn[7:0]] = 1;
    end
  endtask

  task automatic do_flush_all();
    @(negedge clk); flush_all = 1;
    @(negedge clk); flush_all = 0;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) m_vld[s][w] = 0;
  endtask

  task automatic do_flush_ctx(bit [1:0] id);
    @(negedge clk); flush_ctx = 1; flush_id = id;
    @(negedge clk); flush_ctx = 0;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++)
      if (m_ctx[s][w] == id) m_vld[s][w] = 0;
  endtask

  task automatic expect_hit(bit [1:0] ctx, bit [19:0] vpn, bit exp, string rq);
    int s; bit h;
    s = set_of(vpn); h = 0;
    for (int w = 0; w < WAYS; w++)
      if (m_vld[s][w] && m_ctx[s][w] == ctx && m_vpn[s][w] == vpn) h = 1;
    check({rq, " model"}, h, exp);
    access(ctx, vpn, 12'h0, 0, rq);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin
      m_vld[s][w] = 0; m_stamp[s][w] = 0;
    end
    repeat (3) @(negedge clk);
    check("R11 rsp", rsp_valid, 0);
    check("R11 ready", req_ready, 1);
    check("R11 walk", walk_req_valid, 0);
    check("R11 upd", upd_valid, 0);
    rst_n = 1;
    @(negedge clk);
    check("R11 ready after", req_ready, 1);

    // sweep forward and back over 16 pages in 4 sets
    for (int v = 0; v < 16; v++) access(0, 20'(v), 12'(v * 37), 0, "R8 sweep");
    for (int v = 15; v >= 0; v--) access(0, 20'(v), 12'hABC, 0, "R8 back");

    // R2: pages 0,5,10,15 fold to set 0; third evicts the least recent
    do_flush_all();
    expect_hit(0, 0, 0, "R9 flushed");
    access(0, 5, 12'h1, 0, "R2 fill");
    expect_hit(0, 0, 1, "R2 keep");
    access(0, 10, 12'h2, 0, "R2 evict");
    expect_hit(0, 5, 0, "R8 lru victim");
    expect_hit(0, 10, 1, "R2 same set");

    // R3 contexts
    do_flush_all();
    expect_hit(1, 3, 0, "R3 c1");
    expect_hit(2, 3, 0, "R3 c2 no match");
    expect_hit(1, 3, 1, "R3 c1 hit");
    expect_hit(2, 3, 1, "R3 c2 hit");
    expect_hit(3, 3, 0, "R3 c3 pressure");
    expect_hit(1, 3, 0, "R3 c1 evicted");
    // upper tag bits differ, same set
    access(0, 20'h80003, 12'h5, 0, "R3 tag");
    expect_hit(0, 3, 0, "R3 full tag");

    // R6 accessed bit cleared while cached stays clear
    do_flush_all();
    access(0, 20, 12'h0, 0, "R5 fill");
    pt_acc[0][20] = 0;
    access(0, 20, 12'h4, 0, "R6 hit after clear");
    check("R6 acc still clear", pt_acc[0][20], 0);
    access(0, 17, 12'h0, 0, "R6 evict a");
    access(0, 36, 12'h0, 0, "R6 evict b");
    expect_hit(0, 20, 0, "R6 remiss sets acc");

    // R7 dirty
    access(2, 40, 12'h8, 0, "R7 read fill");
    access(2, 40, 12'h8, 1, "R7 write hit clean");
    access(2, 40, 12'h8, 1, "R7 write hit dirty");
    access(2, 41, 12'h9, 1, "R7 write miss");

    // R10 context flush
    do_flush_all();
    access(1, 6, 12'h0, 0, "R10 a");
    access(2, 6, 12'h0, 0, "R10 b");
    do_flush_ctx(1);
    expect_hit(2, 6, 1, "R10 other kept");
    expect_hit(1, 6, 0, "R10 flushed");

    // mixed stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:12] == 4'hF) pt_acc[lfsr[1:0]][{3'b0, lfsr[6:2]}] = 0;
      access(lfsr[1:0], 20'(lfsr[6:2]), lfsr[11:0], lfsr[7] & lfsr[8], "R3 R8 mix");
      if (i == 200) do_flush_ctx(lfsr[10:9]);
      if (i == 300) do_flush_all();
    end
    summary();
  end
endmodule